// File: doc/BRIEF.md
# Serial link control and status register bank

This block is a 32-bit AXI4-Lite slave that lets software manage a set of serial chip-to-chip links. Every link owns a pair of 32-bit words: a control word and a read-only status word. The control word carries one action bit. When software writes a one to it, the block emits a single-cycle, active-high reset pulse on that link's own reset output, and the bit then drops back to zero without any further write.

The status word brings seven per-link health indicators onto the bus. These are channel up, hard error, transceiver PLL lock, link up, configuration error, link error and multi-bit error. Each indicator arrives as a vector with one bit per link, and link n's status word gathers bit n of every vector at the moment the read is accepted. The address and data halves of a write may arrive in any order. Responses are always OKAY.

Top module: `link_ctl_bank`

## Requirements
- R1: After reset, no link reset output is high, bvalid and rvalid are low, and awready, wready and arready are high.
- R2: Link n's control word is at byte address 8*n and its status word at 8*n+4. Address bits [1:0] are ignored.
- R3: A write with wstrb[0]=1 and wdata[0]=1 to link n's control word drives link_rst[n] high for exactly one clock cycle, in the cycle where bvalid first rises. No other link's output changes.
- R4: A control write with wstrb[0]=0, or with wdata[0]=0, produces no reset pulse.
- R5: A write to a status word changes no output and no readable state, and it still completes with a response.
- R6: Status word bit 0 is channel up, bit 1 hard error, bit 2 PLL lock, bit 3 link up, bit 4 configuration error, bit 5 link error and bit 6 multi-bit error. Each bit is taken from bit n of the matching input vector. Bits 31:7 read as zero.
- R7: A control word read returns the current reset bit in bit 0 (one only during the pulse cycle) and zero in bits 31:1.
- R8: Write address and write data are accepted in either order or together. bvalid rises only after both are accepted and stays high until bready. awready and wready are low while a response is pending.
- R9: Read data is registered. rvalid stays high with stable rdata until rready. arready is low while a read response is pending.
- R10: bresp and rresp are always OKAY (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| link_rst | output | N_LINKS | Per-link reset pulses |
| sts_chan_up | input | N_LINKS | Channel up per link |
| sts_hard_err | input | N_LINKS | Hard error per link |
| sts_pll_lock | input | N_LINKS | Transceiver PLL lock per link |
| sts_link_up | input | N_LINKS | Link up per link |
| sts_cfg_err | input | N_LINKS | Configuration error per link |
| sts_link_err | input | N_LINKS | Link error per link |
| sts_mbit_err | input | N_LINKS | Multi-bit error per link |

## Verification
The hardest case to reach from the ports is a control word read that returns a one. The reset bit is high for a single cycle only, so a normal read issued after the write response always sees zero. To reach it, the stimulus presents address and data together, so both are accepted on the same edge. It then raises arvalid exactly one cycle later, which places the read handshake on the edge that closes the pulse cycle. The bench also waits deliberately between the two write halves and holds bready and rready low for several cycles, to show that responses are held and that no new request is accepted in the meantime.

// File: rtl/link_ctl_bank_pkg.sv
package link_ctl_bank_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned STRB_W = DATA_W / 8;
    localparam int unsigned STS_W  = 7;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Field order matters: the last member lands in bit 0.
    typedef struct packed {
        logic mbit_err;
        logic link_err;
        logic cfg_err;
        logic link_up;
        logic pll_lock;
        logic hard_err;
        logic chan_up;
    } link_sts_t;

    typedef enum logic {
        WORD_CTRL = 1'b0,
        WORD_STS  = 1'b1
    } word_kind_e;

    function automatic word_kind_e kind_of(input logic addr_bit2);
        return addr_bit2 ? WORD_STS : WORD_CTRL;
    endfunction

    function automatic logic [DATA_W-1:0] sts_word(input link_sts_t s);
        return {{(DATA_W-STS_W){1'b0}}, s};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input logic rst_bit);
        return {{(DATA_W-1){1'b0}}, rst_bit};
    endfunction

endpackage

// File: rtl/lcb_wr_chan.sv
module lcb_wr_chan
    import link_ctl_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);

    logic aw_full;
    logic w_full;
    logic resp_q;

    assign awready = !aw_full && !resp_q;
    assign wready  = !w_full && !resp_q;
    assign wr_fire = aw_full && w_full && !resp_q;
    assign bvalid  = resp_q;
    assign bresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            resp_q  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_strb <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_full <= 1'b1;
                wr_addr <= awaddr;
            end
            if (wvalid && wready) begin
                w_full  <= 1'b1;
                wr_data <= wdata;
                wr_strb <= wstrb;
            end
            if (wr_fire) begin
                aw_full <= 1'b0;
                w_full  <= 1'b0;
                resp_q  <= 1'b1;
            end else if (resp_q && bready) begin
                resp_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lcb_pulse_bank.sv
module lcb_pulse_bank
    import link_ctl_bank_pkg::*;
#(
    parameter int unsigned N_LINKS = 8,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_fire,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_bit0,
    input  logic               wr_lane0,
    output logic [N_LINKS-1:0] link_rst
);

    localparam int unsigned IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0]   idx;
    logic               arm;
    logic [N_LINKS-1:0] hit;

    assign idx = wr_addr[ADDR_W-1:3];
    assign arm = wr_fire && wr_lane0 && wr_bit0 && (kind_of(wr_addr[2]) == WORD_CTRL);

    for (genvar i = 0; i < N_LINKS; i++) begin : g_link
        assign hit[i] = arm && (idx == IDX_W'(i));
    end

    // Registered hit: high one cycle, then self-clears.
    always_ff @(posedge clk) begin
        if (rst) link_rst <= '0;
        else     link_rst <= hit;
    end

endmodule

// File: rtl/lcb_rd_chan.sv
module lcb_rd_chan
    import link_ctl_bank_pkg::*;
#(
    parameter int unsigned N_LINKS = 8,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arvalid,
    output logic               arready,
    input  logic [ADDR_W-1:0]  araddr,
    output logic               rvalid,
    input  logic               rready,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    input  logic [N_LINKS-1:0] link_rst,
    input  link_sts_t          sts [N_LINKS]
);

    localparam int unsigned IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0]  idx;
    logic              mapped;
    logic [DATA_W-1:0] rd_word;

    assign idx     = araddr[ADDR_W-1:3];
    assign mapped  = {1'b0, idx} < (IDX_W+1)'(N_LINKS);
    assign arready = !rvalid;
    assign rresp   = RESP_OKAY;

    always_comb begin
        rd_word = '0;
        if (mapped) begin
            if (kind_of(araddr[2]) == WORD_CTRL) rd_word = ctrl_word(link_rst[idx]);
            else                                 rd_word = sts_word(sts[idx]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/link_ctl_bank.sv
module link_ctl_bank
    import link_ctl_bank_pkg::*;
#(
    parameter int unsigned N_LINKS = 8,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               awvalid,
    output logic               awready,
    input  logic [ADDR_W-1:0]  awaddr,
    input  logic               wvalid,
    output logic               wready,
    input  logic [31:0]        wdata,
    input  logic [3:0]         wstrb,
    output logic               bvalid,
    input  logic               bready,
    output logic [1:0]         bresp,
    input  logic               arvalid,
    output logic               arready,
    input  logic [ADDR_W-1:0]  araddr,
    output logic               rvalid,
    input  logic               rready,
    output logic [31:0]        rdata,
    output logic [1:0]         rresp,
    output logic [N_LINKS-1:0] link_rst,
    input  logic [N_LINKS-1:0] sts_chan_up,
    input  logic [N_LINKS-1:0] sts_hard_err,
    input  logic [N_LINKS-1:0] sts_pll_lock,
    input  logic [N_LINKS-1:0] sts_link_up,
    input  logic [N_LINKS-1:0] sts_cfg_err,
    input  logic [N_LINKS-1:0] sts_link_err,
    input  logic [N_LINKS-1:0] sts_mbit_err
);

    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    link_sts_t         sts [N_LINKS];

    for (genvar i = 0; i < N_LINKS; i++) begin : g_sts
        assign sts[i] = '{mbit_err: sts_mbit_err[i], link_err: sts_link_err[i],
                          cfg_err:  sts_cfg_err[i],  link_up:  sts_link_up[i],
                          pll_lock: sts_pll_lock[i], hard_err: sts_hard_err[i],
                          chan_up:  sts_chan_up[i]};
    end

    lcb_wr_chan #(.ADDR_W(ADDR_W)) i_wr (
        .clk, .rst, .awvalid, .awready, .awaddr, .wvalid, .wready, .wdata, .wstrb,
        .bvalid, .bready, .bresp, .wr_fire, .wr_addr, .wr_data, .wr_strb
    );

    lcb_pulse_bank #(.N_LINKS(N_LINKS), .ADDR_W(ADDR_W)) i_pulse (
        .clk, .rst, .wr_fire, .wr_addr,
        .wr_bit0(wr_data[0]), .wr_lane0(wr_strb[0]), .link_rst
    );

    lcb_rd_chan #(.N_LINKS(N_LINKS), .ADDR_W(ADDR_W)) i_rd (
        .clk, .rst, .arvalid, .arready, .araddr, .rvalid, .rready, .rdata, .rresp,
        .link_rst, .sts
    );

endmodule

// File: rtl/lcb_checker.sv
module lcb_checker #(
    parameter int unsigned N_LINKS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               awready,
    input logic               wready,
    input logic               bvalid,
    input logic               bready,
    input logic               arready,
    input logic               rvalid,
    input logic               rready,
    input logic [31:0]        rdata,
    input logic [N_LINKS-1:0] link_rst
);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: state right after reset release
    always @(posedge clk) begin
        if (rst_q && !rst) begin
            a_r1_reset_state: assert (link_rst == '0 && !bvalid && !rvalid);
        end
    end

    a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (|link_rst) |=> (link_rst == '0));

    a_r3_pulse_one_link: assert property (@(posedge clk) disable iff (rst)
        $onehot0(link_rst));

    a_r3_pulse_with_resp: assert property (@(posedge clk) disable iff (rst)
        (|link_rst) |-> $rose(bvalid));

    a_r8_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);

    a_r8_no_accept_pending: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> (!awready && !wready));

    a_r9_rvalid_hold: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    a_r9_no_ar_pending: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !arready);

endmodule

bind link_ctl_bank lcb_checker #(.N_LINKS(N_LINKS)) i_chk (.*);

// File: tb/test_link_ctl_bank.sv
module test_link_ctl_bank;

    localparam int N  = 8;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    wstrb = '0;
    logic          awready, wready, bvalid, arready, rvalid;
    logic [1:0]    bresp, rresp;
    logic [31:0]   rdata;
    logic [N-1:0]  link_rst;
    logic [N-1:0]  cup = '0, herr = '0, pll = '0, lup = '0, cerr = '0, lerr = '0, mbe = '0;

    int checks = 0;
    int fails  = 0;
    int pulse_cnt [N];
    int pulse_nob = 0;

    always #10 clk = ~clk;

    link_ctl_bank #(.N_LINKS(N), .ADDR_W(AW)) i_link_ctl_bank (
        .clk, .rst, .awvalid, .awready, .awaddr, .wvalid, .wready, .wdata, .wstrb,
        .bvalid, .bready, .bresp, .arvalid, .arready, .araddr, .rvalid, .rready,
        .rdata, .rresp, .link_rst,
        .sts_chan_up(cup), .sts_hard_err(herr), .sts_pll_lock(pll), .sts_link_up(lup),
        .sts_cfg_err(cerr), .sts_link_err(lerr), .sts_mbit_err(mbe)
    );

    initial for (int i = 0; i < N; i++) pulse_cnt[i] = 0;

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) if (link_rst[i]) pulse_cnt[i]++;
            if (|link_rst && !bvalid) pulse_nob++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sts(input int n);
        return {25'd0, mbe[n], lerr[n], cerr[n], lup[n], pll[n], herr[n], cup[n]};
    endfunction

    task automatic send_aw(input logic [AW-1:0] a);
        bit r;
        awaddr = a; awvalid = 1'b1;
        forever begin
            r = awready;
            @(negedge clk);
            if (r) break;
        end
        awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] d, input logic [3:0] s);
        bit r;
        wdata = d; wstrb = s; wvalid = 1'b1;
        forever begin
            r = wready;
            @(negedge clk);
            if (r) break;
        end
        wvalid = 1'b0;
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int order);
        if (order == 0) begin
            fork send_aw(a); send_w(d, s); join
        end else if (order == 1) begin
            send_aw(a);
            repeat (3) @(negedge clk);
            chk(!bvalid && !awready && wready, "R8 addr alone", {29'd0, bvalid, awready, wready}, 32'd1);
            send_w(d, s);
        end else begin
            send_w(d, s);
            repeat (3) @(negedge clk);
            chk(!bvalid && awready && !wready, "R8 data alone", {29'd0, bvalid, awready, wready}, 32'd2);
            send_aw(a);
        end
        while (!bvalid) @(negedge clk);
        chk(bresp == 2'b00, "R10 bresp", {30'd0, bresp}, 0);
        repeat (2) @(negedge clk);
        chk(bvalid && !awready && !wready, "R8 bvalid held", {29'd0, bvalid, awready, wready}, 32'd4);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        chk(!bvalid, "R8 bvalid drop", {31'd0, bvalid}, 0);
    endtask

    task automatic axi_read(input logic [AW-1:0] a, output logic [31:0] d);
        bit r;
        araddr = a; arvalid = 1'b1;
        forever begin
            r = arready;
            @(negedge clk);
            if (r) break;
        end
        arvalid = 1'b0;
        chk(rvalid && !arready, "R9 rvalid up", {30'd0, rvalid, arready}, 32'd2);
        d = rdata;
        repeat (2) @(negedge clk);
        chk(rvalid && rdata == d, "R9 rdata stable", rdata, d);
        chk(rresp == 2'b00, "R10 rresp", {30'd0, rresp}, 0);
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        chk(!rvalid, "R9 rvalid drop", {31'd0, rvalid}, 0);
    endtask

    task automatic test_reset();
        chk(awready && wready && arready && !bvalid && !rvalid && link_rst == '0,
            "R1 reset state", {27'd0, awready, wready, arready, bvalid, rvalid}, 32'h1c);
    endtask

    task automatic test_status(input logic [N-1:0] p0, input logic [N-1:0] p1);
        logic [31:0] d;
        cup = p0; herr = p1; pll = ~p0; lup = p0 ^ p1; cerr = ~p1; lerr = p0 & p1; mbe = p0 | ~p1;
        for (int n = 0; n < N; n++) begin
            axi_read(AW'(8*n + 4), d);
            chk(d == exp_sts(n), "R6 R2 status word", d, exp_sts(n));
        end
        axi_read(AW'(8*5 + 6), d);
        chk(d == exp_sts(5), "R2 low bits ignored", d, exp_sts(5));
    endtask

    task automatic test_pulses();
        logic [31:0] d;
        int base [N];
        int nob;
        for (int n = 0; n < N; n++) begin
            for (int i = 0; i < N; i++) base[i] = pulse_cnt[i];
            nob = pulse_nob;
            axi_write(AW'(8*n), 32'h0000_0001, 4'b0001, n % 3);
            for (int i = 0; i < N; i++)
                chk(pulse_cnt[i] - base[i] == (i == n ? 1 : 0), "R3 pulse count",
                    pulse_cnt[i] - base[i], (i == n ? 1 : 0));
            chk(pulse_nob == nob, "R3 pulse with bvalid", pulse_nob - nob, 0);
            axi_read(AW'(8*n), d);
            chk(d == 32'd0, "R7 ctrl after pulse", d, 0);
        end
    endtask

    task automatic test_no_pulse();
        int tot;
        tot = 0;
        for (int i = 0; i < N; i++) tot += pulse_cnt[i];
        axi_write(AW'(8*2), 32'hFFFF_FFFF, 4'b1110, 0);
        axi_write(AW'(8*5), 32'hFFFF_FFFE, 4'b1111, 1);
        for (int i = 0; i < N; i++) tot -= pulse_cnt[i];
        chk(tot == 0 && link_rst == '0, "R4 no pulse", -tot, 0);
    endtask

    task automatic test_sts_write();
        logic [31:0] d;
        int tot;
        tot = 0;
        for (int i = 0; i < N; i++) tot += pulse_cnt[i];
        axi_write(AW'(8*3 + 4), 32'hFFFF_FFFF, 4'b1111, 2);
        for (int i = 0; i < N; i++) tot -= pulse_cnt[i];
        chk(tot == 0, "R5 status write no pulse", -tot, 0);
        axi_read(AW'(8*3 + 4), d);
        chk(d == exp_sts(3), "R5 status unchanged", d, exp_sts(3));
        axi_read(AW'(8*3), d);
        chk(d == 32'd0, "R5 ctrl unchanged", d, 0);
    endtask

    // Read handshake placed on the edge closing the pulse cycle.
    task automatic test_read_in_pulse(input int n);
        chk(awready && wready && arready, "R7 ready before", {29'd0, awready, wready, arready}, 7);
        awaddr = AW'(8*n); wdata = 32'h1; wstrb = 4'h1; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        @(negedge clk);
        chk(link_rst == N'(1 << n), "R3 pulse cycle", {24'd0, link_rst}, 32'(1 << n));
        araddr = AW'(8*n); arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        chk(rvalid && rdata == 32'd1, "R7 ctrl reads one in pulse", rdata, 32'd1);
        chk(link_rst == '0, "R3 pulse cleared", {24'd0, link_rst}, 0);
        bready = 1'b1; rready = 1'b1;
        @(negedge clk);
        bready = 1'b0; rready = 1'b0;
        chk(!bvalid && !rvalid, "R8 R9 responses done", {30'd0, bvalid, rvalid}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_status(8'hA5, 8'h3C);
        test_status(8'h0F, 8'hF0);
        test_pulses();
        test_no_pulse();
        test_sts_write();
        test_read_in_pulse(6);
        test_read_in_pulse(1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule